// File: doc/BRIEF.md
# Row-Multiplexed Dot-Matrix Scanner with Duty Dimming

This block drives a bank of 5×7 dot-matrix characters one row at a time. A row timer steps through the seven rows in order. While a row is selected, the block asks the display RAM for that row through a combinational read port. It then presents the returned column bits for every character together with a one-hot row strobe. A three-bit brightness code sets how long each row stays lit. The level follows a fixed, non-linear table that divides each row period into fifteen equal slots. A short dark guard at the end of every row keeps the columns quiet while the row select changes.

The timing base is a multiplex tick, given as a one-cycle enable pulse in the system clock domain. It can come from an internal source or an external one, chosen by a select input. An optional divide-by-16 prescaler sits ahead of the row timer so that a faster external source can be used. A blanking input forces both the strobe and the columns dark without stopping the scan. A peak-current flag passes through a register to the driver-control output.

Top module: `display_row_scanner`

## Requirements
- R1: While `rst_n` is low, the timer sits at row 0, tick 0, and `row_strobe`, `col_data` and `peak_drive` are all zero.
- R2: When `use_internal` is 1, only `int_tick` advances the timer and `ext_tick` has no effect. When `use_internal` is 0, only `ext_tick` advances it and `int_tick` has no effect.
- R3: When `prescale_en` is 1, the timer advances once for every PRESCALE accepted source pulses (16 by default). When it is 0, every accepted pulse advances the timer.
- R4: Each row lasts TICKS_PER_ROW timer advances. Rows run 0,1,…,6 and then return to 0. `ram_row_addr` always shows the current row.
- R5: While lit, `row_strobe` has exactly bit r set for row r (bit 0 is the top row). `col_data` equals the RAM word for that row, in which character n occupies bits [5n+4:5n].
- R6: A row is lit during its first slots×SLOT_TICKS ticks. Brightness codes 0 to 7 give 15, 8, 6, 4, 3, 2, 1 and 0 slots, so code 7 is always dark.
- R7: The last TICKS_PER_ROW − 15×SLOT_TICKS ticks of every row are dark at every brightness. Whenever a row is dark, `row_strobe` and `col_data` are both zero.
- R8: While `blank` is 1, `row_strobe` and `col_data` are zero, but the row timer keeps advancing.
- R9: `peak_drive` equals `peak_full` from the previous clock, whatever the state of `blank`.
- R10: `row_strobe` and `col_data` are registered. They reflect the timer state, the brightness code and `blank` as they stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_tick | input | 1 | Internal multiplex tick pulse |
| ext_tick | input | 1 | External multiplex tick pulse |
| use_internal | input | 1 | 1 selects `int_tick`, 0 selects `ext_tick` |
| prescale_en | input | 1 | 1 divides the selected tick by PRESCALE |
| level | input | 3 | Brightness code, 0 is brightest and 7 is dark |
| blank | input | 1 | Forces the outputs dark |
| peak_full | input | 1 | Peak-current selection flag |
| ram_row_addr | output | 3 | Row index sent to the display RAM read port |
| ram_row_data | input | NUM_CHARS×COLS (40) | Column bits of that row for all characters |
| row_strobe | output | ROWS (7) | One-hot row drive |
| col_data | output | NUM_CHARS×COLS (40) | Column drive |
| peak_drive | output | 1 | Registered peak-current flag |

## Verification
The bench builds the block with TICKS_PER_ROW = 16, SLOT_TICKS = 1 and PRESCALE = 4, and keeps the full size of 8 characters by 7 rows. These settings make a frame only 112 ticks long, so the bench can visit every tick of every row at each of the eight brightness codes. That covers each lit-to-dark edge and the one-tick dark guard. The short prescaler also lets it step through many divide cycles. The source-select, blanking and peak-flag checks run on top of the same running model of the row and tick position.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Number of equal slots a row window is split into for dimming.
  localparam int unsigned DUTY_SLOTS = 15;

  // Lit slots per row for each brightness code (0 brightest, 7 dark).
  function automatic logic [3:0] duty_slots(input logic [2:0] code);
    logic [3:0] s;
    case (code)
      3'd0: s = 4'd15;
      3'd1: s = 4'd8;
      3'd2: s = 4'd6;
      3'd3: s = 4'd4;
      3'd4: s = 4'd3;
      3'd5: s = 4'd2;
      3'd6: s = 4'd1;
      default: s = 4'd0;
    endcase
    return s;
  endfunction

  // Last tick index (exclusive) of the lit part of a row.
  function automatic int unsigned lit_ticks(input logic [2:0] code,
                                            input int unsigned slot_ticks);
    return int'(duty_slots(code)) * slot_ticks;
  endfunction

endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
  parameter int unsigned PRESCALE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic int_tick,
  input  logic ext_tick,
  input  logic use_internal,
  input  logic prescale_en,
  output logic mux_tick
);
  localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic             src_tick;
  logic [PRE_W-1:0] pre_cnt;
  logic             pre_wrap;

  assign src_tick = use_internal ? int_tick : ext_tick;
  assign pre_wrap = (pre_cnt == PRE_W'(PRESCALE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (prescale_en && src_tick) begin
      pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
    end
  end

  assign mux_tick = prescale_en ? (src_tick && pre_wrap) : src_tick;

endmodule

// File: rtl/scan_row_timer.sv
module scan_row_timer #(
  parameter int unsigned TICKS_PER_ROW = 64,
  parameter int unsigned ROWS          = 7,
  localparam int unsigned TICK_W       = $clog2(TICKS_PER_ROW),
  localparam int unsigned ROW_W        = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mux_tick,
  output logic [TICK_W-1:0] tick_idx,
  output logic [ROW_W-1:0]  row_idx,
  output logic              row_end
);
  logic last_tick;
  logic last_row;

  assign last_tick = (tick_idx == TICK_W'(TICKS_PER_ROW - 1));
  assign last_row  = (row_idx == ROW_W'(ROWS - 1));
  assign row_end   = mux_tick && last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_idx <= '0;
      row_idx  <= '0;
    end else if (mux_tick) begin
      tick_idx <= last_tick ? '0 : tick_idx + 1'b1;
      if (last_tick) begin
        row_idx <= last_row ? '0 : row_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/scan_window.sv
module scan_window
  import scan_pkg::*;
#(
  parameter int unsigned TICKS_PER_ROW = 64,
  parameter int unsigned SLOT_TICKS    = 4,
  localparam int unsigned TICK_W       = $clog2(TICKS_PER_ROW),
  localparam int unsigned LIM_W        = TICK_W + 5
) (
  input  logic [TICK_W-1:0] tick_idx,
  input  logic [2:0]        level,
  input  logic              blank,
  output logic              window_on
);
  logic [LIM_W-1:0] lit_limit;

  assign lit_limit = LIM_W'(lit_ticks(level, SLOT_TICKS));
  assign window_on = !blank && ({{(LIM_W-TICK_W){1'b0}}, tick_idx} < lit_limit);

endmodule

// File: rtl/display_row_scanner.sv
module display_row_scanner
  import scan_pkg::*;
#(
  parameter int unsigned NUM_CHARS     = 8,
  parameter int unsigned COLS          = 5,
  parameter int unsigned ROWS          = 7,
  parameter int unsigned TICKS_PER_ROW = 64,
  parameter int unsigned SLOT_TICKS    = 4,
  parameter int unsigned PRESCALE      = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          int_tick,
  input  logic                          ext_tick,
  input  logic                          use_internal,
  input  logic                          prescale_en,
  input  logic [2:0]                    level,
  input  logic                          blank,
  input  logic                          peak_full,
  output logic [$clog2(ROWS)-1:0]       ram_row_addr,
  input  logic [NUM_CHARS*COLS-1:0]     ram_row_data,
  output logic [ROWS-1:0]               row_strobe,
  output logic [NUM_CHARS*COLS-1:0]     col_data,
  output logic                          peak_drive
);
  localparam int unsigned TICK_W = $clog2(TICKS_PER_ROW);
  localparam int unsigned ROW_W  = $clog2(ROWS);
  localparam int unsigned DATA_W = NUM_CHARS * COLS;

  // Named internal events, observed by the checker.
  logic              mux_tick;
  logic [TICK_W-1:0] tick_idx;
  logic [ROW_W-1:0]  row_idx;
  logic              row_end;
  logic              window_on;
  logic [ROWS-1:0]   strobe_next;

  scan_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk          (clk),
    .rst_n        (rst_n),
    .int_tick     (int_tick),
    .ext_tick     (ext_tick),
    .use_internal (use_internal),
    .prescale_en  (prescale_en),
    .mux_tick     (mux_tick)
  );

  scan_row_timer #(.TICKS_PER_ROW(TICKS_PER_ROW), .ROWS(ROWS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .mux_tick (mux_tick),
    .tick_idx (tick_idx),
    .row_idx  (row_idx),
    .row_end  (row_end)
  );

  scan_window #(.TICKS_PER_ROW(TICKS_PER_ROW), .SLOT_TICKS(SLOT_TICKS)) u_window (
    .tick_idx  (tick_idx),
    .level     (level),
    .blank     (blank),
    .window_on (window_on)
  );

  assign ram_row_addr = row_idx;

  for (genvar g = 0; g < ROWS; g++) begin : g_strobe
    assign strobe_next[g] = window_on && (row_idx == ROW_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_strobe <= '0;
      col_data   <= '0;
      peak_drive <= 1'b0;
    end else begin
      row_strobe <= strobe_next;
      col_data   <= window_on ? ram_row_data : {DATA_W{1'b0}};
      peak_drive <= peak_full;
    end
  end

endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
  parameter int unsigned ROWS          = 7,
  parameter int unsigned TICKS_PER_ROW = 64,
  parameter int unsigned SLOT_TICKS    = 4,
  parameter int unsigned DATA_W        = 40,
  localparam int unsigned TICK_W       = $clog2(TICKS_PER_ROW),
  localparam int unsigned ROW_W        = $clog2(ROWS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mux_tick,
  input logic [TICK_W-1:0] tick_idx,
  input logic [ROW_W-1:0]  row_idx,
  input logic              blank,
  input logic              peak_full,
  input logic              peak_drive,
  input logic [ROWS-1:0]   row_strobe,
  input logic [DATA_W-1:0] col_data
);
  localparam int unsigned GUARD_START = 15 * SLOT_TICKS;

  // R5
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_strobe));

  // R7
  dark_cols_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_strobe == '0) |-> (col_data == '0));

  // R4
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(row_idx) < ROWS));

  // R4
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_tick && tick_idx == TICK_W'(TICKS_PER_ROW - 1)) |=>
    (row_idx == (($past(row_idx) == ROW_W'(ROWS - 1)) ? '0 : $past(row_idx) + 1'b1)));

  // R7
  guard_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tick_idx) >= GUARD_START) |=> (row_strobe == '0));

  // R8
  blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> (row_strobe == '0 && col_data == '0));

  // R9
  peak_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (peak_drive == $past(peak_full)));

endmodule

bind display_row_scanner scan_checker #(
  .ROWS          (ROWS),
  .TICKS_PER_ROW (TICKS_PER_ROW),
  .SLOT_TICKS    (SLOT_TICKS),
  .DATA_W        (NUM_CHARS * COLS)
) u_scan_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .mux_tick   (mux_tick),
  .tick_idx   (tick_idx),
  .row_idx    (row_idx),
  .blank      (blank),
  .peak_full  (peak_full),
  .peak_drive (peak_drive),
  .row_strobe (row_strobe),
  .col_data   (col_data)
);

// File: tb/test_display_row_scanner.sv
`timescale 1ns/1ps
module test_display_row_scanner;
  localparam int NCH  = 8;
  localparam int NCOL = 5;
  localparam int NROW = 7;
  localparam int TPR  = 16;
  localparam int SLT  = 1;
  localparam int PRE  = 4;
  localparam int DW   = NCH * NCOL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          int_tick = 1'b0;
  logic          ext_tick = 1'b0;
  logic          use_internal = 1'b0;
  logic          prescale_en = 1'b0;
  logic [2:0]    level = 3'd0;
  logic          blank = 1'b0;
  logic          peak_full = 1'b0;
  logic [2:0]    ram_row_addr;
  logic [DW-1:0] ram_row_data;
  logic [NROW-1:0] row_strobe;
  logic [DW-1:0] col_data;
  logic          peak_drive;

  int n_checks = 0;
  int n_fail   = 0;
  int advances = 0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] pat(input int r);
    logic [7:0] b;
    b = 8'((r + 1) * 27) ^ 8'hC6;
    return {NCH*NCOL/8{b}};
  endfunction

  assign ram_row_data = pat(int'(ram_row_addr));

  // Brightness in tenths of a percent, rounded onto a 15-slot window.
  function automatic int lit_len(input int code);
    int pm;
    case (code)
      0: pm = 1000; 1: pm = 530; 2: pm = 400; 3: pm = 270;
      4: pm = 200;  5: pm = 130; 6: pm = 66;  default: pm = 0;
    endcase
    return ((pm * 15 + 500) / 1000) * SLT;
  endfunction

  display_row_scanner #(
    .NUM_CHARS(NCH), .COLS(NCOL), .ROWS(NROW),
    .TICKS_PER_ROW(TPR), .SLOT_TICKS(SLT), .PRESCALE(PRE)
  ) i_display_row_scanner (
    .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .ext_tick(ext_tick),
    .use_internal(use_internal), .prescale_en(prescale_en), .level(level),
    .blank(blank), .peak_full(peak_full), .ram_row_addr(ram_row_addr),
    .ram_row_data(ram_row_data), .row_strobe(row_strobe), .col_data(col_data),
    .peak_drive(peak_drive)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Compare every output with the model at the current position.
  task automatic check_state(input string req);
    int row, t;
    bit on;
    row = (advances / TPR) % NROW;
    t   = advances % TPR;
    on  = !blank && (t < lit_len(int'(level)));
    check({req, " addr"},   64'(ram_row_addr), 64'(row));
    check({req, " strobe"}, 64'(row_strobe), on ? 64'(1 << row) : 64'd0);
    check({req, " cols"},   64'(col_data), on ? 64'(pat(row)) : 64'd0);
  endtask

  task automatic pulse(input bit use_int);
    @(negedge clk);
    if (use_int) int_tick = 1'b1; else ext_tick = 1'b1;
    @(negedge clk);
    int_tick = 1'b0;
    ext_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 strobe", 64'(row_strobe), 64'd0);
    check("R1 cols", 64'(col_data), 64'd0);
    check("R1 peak", 64'(peak_drive), 64'd0);
    check("R1 addr", 64'(ram_row_addr), 64'd0);
    rst_n = 1'b1;
    settle();
    check_state("R1 after release");

    // R4 R5 R6 R7 R10: every tick of a full frame at every brightness code
    for (int code = 0; code < 8; code++) begin
      level = 3'(code);
      settle();
      for (int k = 0; k < NROW * TPR; k++) begin
        check_state("R6 sweep");
        pulse(1'b0);
        advances++;
      end
      check_state("R4 frame wrap");
    end

    // R8: blank hides output but timer still runs
    level = 3'd0;
    blank = 1'b1;
    settle();
    for (int k = 0; k < 20; k++) begin
      pulse(1'b0);
      advances++;
      check_state("R8 blanked");
    end
    blank = 1'b0;
    settle();
    check_state("R8 resumed");

    // R9: peak flag registered through
    @(negedge clk) peak_full = 1'b1;
    check("R9 before edge", 64'(peak_drive), 64'd0);
    @(negedge clk);
    check("R9 high", 64'(peak_drive), 64'd1);
    blank = 1'b1;
    @(negedge clk) peak_full = 1'b0;
    @(negedge clk);
    check("R9 low with blank", 64'(peak_drive), 64'd0);
    blank = 1'b0;
    settle();

    // R2: source select
    use_internal = 1'b1;
    settle();
    for (int k = 0; k < 3; k++) begin
      pulse(1'b0);
      check_state("R2 ext ignored");
    end
    for (int k = 0; k < 5; k++) begin
      pulse(1'b1);
      advances++;
      check_state("R2 int used");
    end
    use_internal = 1'b0;
    settle();
    pulse(1'b1);
    check_state("R2 int ignored");

    // R3: prescaler divides by PRE
    prescale_en = 1'b1;
    settle();
    for (int k = 0; k < PRE * 40; k++) begin
      pulse(1'b0);
      if ((k % PRE) == PRE - 1) advances++;
      check_state("R3 prescaled");
    end
    prescale_en = 1'b0;
    settle();
    pulse(1'b0);
    advances++;
    check_state("R3 bypass");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule